// File: doc/BRIEF.md
# Silent Store Pair Predictor

This block decides when a pair of stores can be elided as a unit. The first store of a pair changes a memory word (for example, a lock acquire). The second store later writes the original value back (the release). The block keeps a table of confidence counters, indexed and tagged by the program counter of the first store. When a store arrives from a confident entry, and the lock-held hint is low, the block pulses a start signal. The store is then not performed. The block records the store's address and the value that the store would have overwritten. It then watches that address. A later store that writes the recorded value back validates the pair, and both stores are dropped. A later store to that address with any other value ends the attempt with a fail pulse.

While an entry lacks confidence, the block still watches the store's address, but without speculating. This training watch teaches the counter whether this program counter really starts silent pairs. Training produces no output pulses. Only one watch, either training or speculative, exists at any time. Cache, coherence and pipeline recovery belong to the surrounding logic.

Top module: `silent_pair_predictor`

## Requirements
- R1: After reset all three output pulses are low and every table entry is invalid, so the first store seen from any program counter cannot start elision.
- R2: The table has 32 entries. The index is pc[6:2] and the tag is pc[31:7]. When the block is idle and the lock-held hint is low, a store that misses allocates its entry with confidence 0 and begins a training watch.
- R3: Each entry holds a 2-bit saturating confidence. When a watch ends, the counter of the entry that opened the watch is updated. A restoring store raises it by one, with a maximum of 3. Any other store to the watched address lowers it by one, with a minimum of 0.
- R4: A store that hits an entry with confidence of at least 2, while the block is idle and the lock-held hint is low, produces elide_start. The pulse is high for exactly one cycle, in the cycle after the store is presented. This store opens a speculative watch.
- R5: A store presented with the lock-held hint high, while the block is idle, is ignored. It allocates nothing, starts nothing and opens no watch.
- R6: When a watch opens, the block records the store's address and its old memory value. During a speculative watch, a later store to the recorded address whose data equals the recorded value produces pair_valid one cycle later and returns the block to idle.
- R7: During a speculative watch, a later store to the recorded address with any other data produces pair_fail one cycle later and returns the block to idle.
- R8: At most one watch is open. While a watch is open, stores to other addresses are ignored, including confident candidates. They neither start nor end anything, and they leave the table unchanged.
- R9: A training watch never raises elide_start, pair_valid or pair_fail. It ends under the same store rules as a speculative watch.
- R10: A store whose index matches a valid entry but whose tag differs replaces that entry with confidence 0, and it does not start elision.
- R11: At most one of elide_start, pair_valid and pair_fail is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | A store is presented this cycle |
| st_pc | input | 32 | Program counter of the store |
| st_addr | input | 32 | Word address of the store |
| st_data | input | 32 | Value the store writes |
| st_old | input | 32 | Current memory value at st_addr |
| lock_held | input | 1 | Hint that the location is already held |
| elide_start | output | 1 | One-cycle pulse: this store is elided and a speculative watch opens |
| pair_valid | output | 1 | One-cycle pulse: the pair is validated and both stores are dropped |
| pair_fail | output | 1 | One-cycle pulse: speculation failed on a non-restoring store |

## Verification
The assertions assume several things about the inputs. At most one store is presented per cycle. st_valid is low during reset. The lock-held hint matters only in the cycle of a store. The stimulus respects all of these. It drives one store per presentation at the falling edge, and it keeps st_valid low while reset is active. The random stimulus uses a few program counters that alias on the same index, and a few addresses. The data values are small, so that restoring stores, mismatching stores and lock-held cases all occur often.

// File: rtl/spp_pkg.sv
package spp_pkg;
    typedef enum logic [1:0] {
        W_IDLE  = 2'd0,
        W_TRAIN = 2'd1,
        W_SPEC  = 2'd2
    } watch_e;
endpackage

// File: rtl/spp_pc_split.sv
module spp_pc_split #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 5,
    parameter int TAG_W = 25
) (
    input  logic [PC_W-1:0]  pc_i,
    output logic [IDX_W-1:0] idx_o,
    output logic [TAG_W-1:0] tag_o
);
    // instructions are word aligned: bits [1:0] carry no information
    assign idx_o = pc_i[2 +: IDX_W];
    assign tag_o = pc_i[PC_W-1 -: TAG_W];
endmodule

// File: rtl/spp_conf_step.sv
module spp_conf_step #(
    parameter int CONF_W = 2
) (
    input  logic [CONF_W-1:0] conf_i,
    input  logic              up_i,
    output logic [CONF_W-1:0] conf_o
);
    localparam logic [CONF_W-1:0] CMAX = {CONF_W{1'b1}};

    always_comb begin
        if (up_i) begin
            conf_o = (conf_i == CMAX) ? conf_i : conf_i + 1'b1;
        end else begin
            conf_o = (conf_i == '0) ? conf_i : conf_i - 1'b1;
        end
    end
endmodule

// File: rtl/silent_pair_predictor.sv
module silent_pair_predictor #(
    parameter int PC_W        = 32,
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int ENTRIES     = 32,
    parameter int CONF_W      = 2,
    parameter int CONF_THRESH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_valid,
    input  logic [PC_W-1:0]   st_pc,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_data,
    input  logic [DATA_W-1:0] st_old,
    input  logic              lock_held,
    output logic              elide_start,
    output logic              pair_valid,
    output logic              pair_fail
);
    import spp_pkg::*;

    localparam int IDX_W = $clog2(ENTRIES);
    localparam int TAG_W = PC_W - IDX_W - 2;
    localparam logic [CONF_W-1:0] THRESH = CONF_W'(CONF_THRESH);

    typedef struct packed {
        logic [ENTRIES-1:0]             vld;
        logic [ENTRIES-1:0][TAG_W-1:0]  tag;
        logic [ENTRIES-1:0][CONF_W-1:0] conf;
        watch_e                         mode;
        logic [IDX_W-1:0]               widx;
        logic [ADDR_W-1:0]              waddr;
        logic [DATA_W-1:0]              wdata;
        logic                           start;
        logic                           valid;
        logic                           fail;
    } state_t;

    state_t s_d, s_q;

    logic [IDX_W-1:0]  idx;
    logic [TAG_W-1:0]  tag;
    logic [CONF_W-1:0] conf_next;
    logic              restore;

    spp_pc_split #(.PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_split (
        .pc_i  (st_pc),
        .idx_o (idx),
        .tag_o (tag)
    );

    assign restore = (st_data == s_q.wdata);

    spp_conf_step #(.CONF_W(CONF_W)) u_step (
        .conf_i (s_q.conf[s_q.widx]),
        .up_i   (restore),
        .conf_o (conf_next)
    );

    always_comb begin
        s_d       = s_q;
        s_d.start = 1'b0;
        s_d.valid = 1'b0;
        s_d.fail  = 1'b0;
        if (st_valid) begin
            if (s_q.mode != W_IDLE && st_addr == s_q.waddr) begin
                // closing store of the watched pair
                s_d.conf[s_q.widx] = conf_next;
                if (s_q.mode == W_SPEC) begin
                    s_d.valid = restore;
                    s_d.fail  = !restore;
                end
                s_d.mode = W_IDLE;
            end else if (s_q.mode == W_IDLE && !lock_held) begin
                s_d.widx  = idx;
                s_d.waddr = st_addr;
                s_d.wdata = st_old;
                if (!(s_q.vld[idx] && s_q.tag[idx] == tag)) begin
                    s_d.vld[idx]  = 1'b1;
                    s_d.tag[idx]  = tag;
                    s_d.conf[idx] = '0;
                    s_d.mode      = W_TRAIN;
                end else if (s_q.conf[idx] >= THRESH) begin
                    s_d.mode  = W_SPEC;
                    s_d.start = 1'b1;
                end else begin
                    s_d.mode = W_TRAIN;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign elide_start = s_q.start;
    assign pair_valid  = s_q.valid;
    assign pair_fail   = s_q.fail;

    assert_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({elide_start, pair_valid, pair_fail}));

    assert_start_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        elide_start |-> $past(st_valid && !lock_held));

    assert_start_spec_R4: assert property (@(posedge clk) disable iff (!rst_n)
        elide_start |-> s_q.mode == W_SPEC);

    assert_end_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_valid || pair_fail) |-> s_q.mode == W_IDLE);

    assert_single_watch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        elide_start |=> !elide_start);

    assert_close_needs_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_valid || pair_fail) |-> $past(st_valid));
endmodule

// File: tb/tb_silent_pair_predictor.sv
module tb_silent_pair_predictor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st_valid = 1'b0;
    logic [31:0] st_pc = '0, st_addr = '0, st_data = '0, st_old = '0;
    logic        lock_held = 1'b0;
    logic        elide_start, pair_valid, pair_fail;

    int errors = 0;
    int checks = 0;

    // reference model (built from the requirements)
    logic        m_vld [32];
    logic [24:0] m_tag [32];
    int          m_conf [32];
    int          m_mode;          // 0 idle, 1 train, 2 spec
    int          m_widx;
    logic [31:0] m_waddr, m_wdata;

    always #2.5 clk = ~clk;

    silent_pair_predictor dut (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_pc(st_pc),
        .st_addr(st_addr), .st_data(st_data), .st_old(st_old),
        .lock_held(lock_held), .elide_start(elide_start),
        .pair_valid(pair_valid), .pair_fail(pair_fail)
    );

    function automatic logic [2:0] model_store(logic [31:0] pc, logic [31:0] a,
                                               logic [31:0] d, logic [31:0] o, logic lk);
        logic [2:0] r = 3'b000;   // {start, valid, fail}
        int ix = int'(pc[6:2]);
        if (m_mode != 0 && a == m_waddr) begin
            if (d == m_wdata) begin
                if (m_conf[m_widx] < 3) m_conf[m_widx]++;
                if (m_mode == 2) r = 3'b010;
            end else begin
                if (m_conf[m_widx] > 0) m_conf[m_widx]--;
                if (m_mode == 2) r = 3'b001;
            end
            m_mode = 0;
        end else if (m_mode == 0 && !lk) begin
            m_widx = ix; m_waddr = a; m_wdata = o;
            if (!(m_vld[ix] && m_tag[ix] == pc[31:7])) begin
                m_vld[ix] = 1'b1; m_tag[ix] = pc[31:7]; m_conf[ix] = 0; m_mode = 1;
            end else if (m_conf[ix] >= 2) begin
                m_mode = 2; r = 3'b100;
            end else begin
                m_mode = 1;
            end
        end
        return r;
    endfunction

    task automatic check(string req, logic [2:0] act, logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: outputs {start,valid,fail} actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic do_store(string req, logic [31:0] pc, logic [31:0] a,
                            logic [31:0] d, logic [31:0] o, logic lk);
        logic [2:0] exp;
        exp = model_store(pc, a, d, o, lk);
        st_valid = 1'b1; st_pc = pc; st_addr = a; st_data = d; st_old = o; lock_held = lk;
        @(posedge clk);
        @(negedge clk);
        st_valid = 1'b0; lock_held = 1'b0;
        check(req, {elide_start, pair_valid, pair_fail}, exp);
    endtask

    initial begin
        #1ms;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    localparam logic [31:0] P  = 32'h0000_0100;   // index 0
    localparam logic [31:0] PA = 32'h0000_0180;   // index 0, other tag
    localparam logic [31:0] Q  = 32'h0000_0204;   // index 1
    localparam logic [31:0] A  = 32'h40, B = 32'h80;

    initial begin
        logic [31:0] pcs [4];
        logic [31:0] adr [3];
        for (int i = 0; i < 32; i++) begin m_vld[i] = 0; m_tag[i] = '0; m_conf[i] = 0; end
        m_mode = 0; m_widx = 0; m_waddr = '0; m_wdata = '0;
        repeat (3) @(negedge clk);
        check("R1 reset", {elide_start, pair_valid, pair_fail}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", {elide_start, pair_valid, pair_fail}, 3'b000);

        do_store("R2 miss allocates", P, A, 32'd1, 32'd0, 1'b0);
        do_store("R8 other address ignored", Q, B, 32'd7, 32'd3, 1'b0);
        do_store("R9 training restore silent", 32'h300, A, 32'd0, 32'd1, 1'b0); // conf 1
        do_store("R9 training below threshold", P, A, 32'd1, 32'd0, 1'b0);
        do_store("R3 training raises conf", 32'h300, A, 32'd0, 32'd1, 1'b0);   // conf 2
        do_store("R5 lock held ignored", P, A, 32'd1, 32'd0, 1'b1);
        do_store("R4 confident start", P, A, 32'd1, 32'd0, 1'b0);
        do_store("R8 candidate ignored while active", P, B, 32'd1, 32'd0, 1'b0);
        do_store("R7 mismatch fails", 32'h300, A, 32'd5, 32'd1, 1'b0);       // conf 1
        do_store("R3 below threshold after fail", P, A, 32'd1, 32'd0, 1'b0);
        do_store("R3 train restore", 32'h300, A, 32'd0, 32'd1, 1'b0);        // conf 2
        do_store("R4 start again", P, A, 32'd1, 32'd0, 1'b0);
        do_store("R6 restore validates", 32'h300, A, 32'd0, 32'd1, 1'b0);    // conf 3
        do_store("R4 start", P, A, 32'd1, 32'd0, 1'b0);
        do_store("R6 validate at saturation", 32'h300, A, 32'd0, 32'd1, 1'b0); // conf 3
        do_store("R4 start", P, A, 32'd1, 32'd0, 1'b0);
        do_store("R7 fail from 3", 32'h300, A, 32'd9, 32'd1, 1'b0);          // conf 2
        do_store("R3 still confident", P, A, 32'd1, 32'd0, 1'b0);
        do_store("R7 fail from 2", 32'h300, A, 32'd9, 32'd1, 1'b0);          // conf 1
        do_store("R3 no start at 1", P, A, 32'd1, 32'd0, 1'b0);
        do_store("R9 training mismatch silent", 32'h300, A, 32'd4, 32'd1, 1'b0);
        do_store("R10 alias replaces entry", PA, B, 32'd1, 32'd0, 1'b0);
        do_store("R9 close alias watch", 32'h300, B, 32'd0, 32'd1, 1'b0);
        do_store("R10 original pc misses", P, A, 32'd1, 32'd0, 1'b0);

        // constrained random phase, fixed seed
        pcs[0] = P; pcs[1] = PA; pcs[2] = Q; pcs[3] = 32'h0000_1204;
        adr[0] = A; adr[1] = B; adr[2] = 32'hC0;
        void'($urandom(32'd12345));
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] pc, a, d, o;
            logic        lk;
            logic [2:0]  e_peek;
            string       tag_s;
            pc = pcs[$urandom_range(3)];
            lk = ($urandom_range(7) == 0);
            o  = 32'($urandom_range(1));
            if (m_mode != 0 && $urandom_range(1) == 1) begin
                a = m_waddr;
                d = ($urandom_range(3) == 0) ? 32'd2 : m_wdata;
            end else begin
                a = adr[$urandom_range(2)];
                d = 32'($urandom_range(2));
            end
            e_peek = 3'b000;
            if (m_mode == 2 && a == m_waddr) e_peek = (d == m_wdata) ? 3'b010 : 3'b001;
            tag_s = (e_peek == 3'b010) ? "R6 random" :
                    (e_peek == 3'b001) ? "R7 random" :
                    lk ? "R5 random" : "R4 random";
            do_store(tag_s, pc, a, d, o, lk);
            if ($urandom_range(3) == 0) begin
                @(negedge clk);
                check("R11 idle cycle quiet", {elide_start, pair_valid, pair_fail}, 3'b000);
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule